// File: doc/BRIEF.md
# Edge-Latched Interrupt Collector With Split Status

This block gathers eleven external edge-signalled interrupt lines of the classic ISA numbering into one host interrupt. Each line first passes through a two-flop synchronizer. A rising edge seen after synchronization sets a sticky status bit, and that bit stays set until software acknowledges it. Software sees the eleven status bits through two byte registers. The low one holds bits 0 to 7. The high one holds bits 8 to 10 in its lowest three positions. Writing a one to a position clears that bit.

An enable mask, split across two registers in the same way, selects which status bits count as pending. The host interrupt is high whenever any pending bit is set. The block also reports the lowest-numbered pending bit, both as a status index and as its ISA line number. A small combinational lookup converts an ISA line number into its status-bit mask. Lines that have no status bit return an empty mask.

Top module: `isa_edge_irq_agg`

## Requirements
- R1: A rising edge on `irq_in[k]` sets status bit k on the third rising clock edge after the input changes. The path is two synchronizer flops followed by one status flop. An input held high, or a falling edge, does not set the bit again once it has been cleared.
- R2: Status bits 0 to 10 stand for ISA lines 3, 4, 5, 6, 7, 10, 11, 12, 9, 14 and 15, in that order. `pend_line` gives the line of the bit reported on `pend_idx`.
- R3: Reading address 0 returns status bits 7:0. Reading address 1 returns status bits 10:8 in data bits 2:0, and data bits 7:3 read as zero.
- R4: A write to address 0 clears each status bit 7:0 whose data bit is one. A write to address 1 clears status bit 8+j for each data bit j in 2:0 that is one. Zero data bits have no effect, and data bits 7:3 at address 1 are ignored.
- R5: A set status bit holds its value with no acknowledge, whatever its input does.
- R6: Address 2 reads and writes enable bits 7:0. Address 3 reads and writes enable bits 10:8 in data bits 2:0, and its bits 7:3 read as zero. Pending is status AND enable. `irq_out` is high exactly when pending is nonzero. A masked bit stays visible in status.
- R7: `pend_valid` equals `irq_out`. `pend_idx` is the lowest set pending bit. With nothing pending, `pend_idx` and `pend_line` are zero.
- R8: When an edge and an acknowledge of the same bit take effect on the same clock, the bit is left set.
- R9: `map_mask` has a one only at the status bit of ISA line `map_line`. Lines 0, 1, 2, 8 and 13 give all zeros.
- R10: After reset, status and enable are zero, and `irq_out` and `pend_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 11 | Raw interrupt lines, indexed by status bit |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 2 | Register select: 0/1 status low/high, 2/3 enable low/high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Summary interrupt |
| pend_valid | output | 1 | Some bit is pending |
| pend_idx | output | 4 | Lowest pending status bit |
| pend_line | output | 4 | ISA line of `pend_idx` |
| map_line | input | 4 | ISA line number to translate |
| map_mask | output | 11 | Status-bit mask for `map_line` |

## Verification
The hardest case to reach from the ports is a new edge and a software acknowledge of the same bit landing on one clock edge. The bench first leaves the bit set. It then raises the input two cycles before a write, so that the synchronized edge and the write strobe meet on the same clock. The bit must read back as set afterwards, and a later acknowledge with the input still high must clear it for good. The remaining checks cover the non-monotonic line order through the priority outputs, and masked bits that stay set but raise no interrupt.

// File: rtl/isa_edge_irq_agg.sv
module isa_edge_irq_agg #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [10:0] irq_in,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq_out,
  output logic        pend_valid,
  output logic [3:0]  pend_idx,
  output logic [3:0]  pend_line,
  input  logic [3:0]  map_line,
  output logic [10:0] map_mask
);
  localparam int NSRC = 11;
  localparam int HIW  = NSRC - DW;

  function automatic logic [3:0] line_of(input int k);
    case (k)
      0: line_of = 4'd3;
      1: line_of = 4'd4;
      2: line_of = 4'd5;
      3: line_of = 4'd6;
      4: line_of = 4'd7;
      5: line_of = 4'd10;
      6: line_of = 4'd11;
      7: line_of = 4'd12;
      8: line_of = 4'd9;
      9: line_of = 4'd14;
      10: line_of = 4'd15;
      default: line_of = 4'd0;
    endcase
  endfunction

  logic [NSRC-1:0] sync_q [SYNC];
  logic [NSRC-1:0] prev_q, status, mask, edge_det, ack, pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= irq_in;
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign edge_det = sync_q[SYNC-1] & ~prev_q;

  always_comb begin
    ack = '0;
    if (reg_wr && reg_addr == 2'd0) ack = {{HIW{1'b0}}, reg_wdata};
    if (reg_wr && reg_addr == 2'd1) ack = {reg_wdata[HIW-1:0], {DW{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= (status & ~ack) | edge_det;
      if (reg_wr && reg_addr == 2'd2) mask[DW-1:0] <= reg_wdata;
      if (reg_wr && reg_addr == 2'd3) mask[NSRC-1:DW] <= reg_wdata[HIW-1:0];
    end
  end

  assign pending    = status & mask;
  assign irq_out    = |pending;
  assign pend_valid = irq_out;

  always_comb begin
    pend_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pending[i]) pend_idx = 4'(i);
  end

  assign pend_line = pend_valid ? line_of(int'(pend_idx)) : 4'd0;

  always_comb begin
    map_mask = '0;
    for (int k = 0; k < NSRC; k++)
      if (line_of(k) == map_line) map_mask[k] = 1'b1;
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = status[DW-1:0];
      2'd1:    reg_rdata = {{(DW-HIW){1'b0}}, status[NSRC-1:DW]};
      2'd2:    reg_rdata = mask[DW-1:0];
      default: reg_rdata = {{(DW-HIW){1'b0}}, mask[NSRC-1:DW]};
    endcase
  end
endmodule

// File: rtl/isa_edge_irq_agg_chk.sv
module isa_edge_irq_agg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic        irq_out,
  input logic        pend_valid,
  input logic [3:0]  pend_idx,
  input logic [10:0] status,
  input logic [10:0] mask,
  input logic [10:0] edge_det
);
  logic [10:0] pend_bits;
  assign pend_bits = status & mask;

  a_r4_low_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && edge_det == 11'd0) |=> ((status[7:0] & $past(reg_wdata)) == 8'd0));

  a_r5_hold_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && edge_det == 11'd0) |=> $stable(status));

  a_r8_edge_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_det != 11'd0) |=> ((status & $past(edge_det)) == $past(edge_det)));

  a_r7_valid_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid == irq_out);

  a_r7_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (pend_bits[pend_idx] && ((pend_bits & ((11'd1 << pend_idx) - 11'd1)) == 11'd0)));

  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((status & mask) != 11'd0));
endmodule

bind isa_edge_irq_agg isa_edge_irq_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_out(irq_out), .pend_valid(pend_valid),
  .pend_idx(pend_idx), .status(status), .mask(mask), .edge_det(edge_det)
);

// File: tb/isa_edge_irq_agg_test.sv
module isa_edge_irq_agg_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [10:0] irq_in;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        irq_out, pend_valid;
  logic [3:0]  pend_idx, pend_line, map_line;
  logic [10:0] map_mask;

  isa_edge_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .pend_valid(pend_valid), .pend_idx(pend_idx),
    .pend_line(pend_line), .map_line(map_line), .map_mask(map_mask)
  );

  typedef struct { int kind; int exp; string tag; } item_t;
  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int lines [11] = '{3, 4, 5, 6, 7, 10, 11, 12, 9, 14, 15};

  function automatic int observe(input int kind);
    case (kind)
      0: observe = int'(reg_rdata);
      1: observe = int'(irq_out);
      2: observe = int'(pend_valid);
      3: observe = int'(pend_idx);
      4: observe = int'(pend_line);
      default: observe = int'(map_mask);
    endcase
  endfunction

  initial begin
    forever begin : mon_b
      item_t it;
      int act;
      while (q.size() == 0) #1;
      #2;
      it = q.pop_front();
      act = observe(it.kind);
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(input int kind, input logic [1:0] a, input int e, input string tag);
    item_t it;
    reg_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    #5;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic pulse(input int b);
    irq_in[b] = 1'b1;
    tick(4);
    irq_in[b] = 1'b0;
    tick(3);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00; map_line = 4'd0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R10 reset state
    expect_val(0, 2'd0, 0, "R10 status low");
    expect_val(0, 2'd1, 0, "R10 status high");
    expect_val(0, 2'd2, 0, "R10 enable low");
    expect_val(0, 2'd3, 0, "R10 enable high");
    expect_val(1, 2'd0, 0, "R10 irq_out");
    expect_val(2, 2'd0, 0, "R10 pend_valid");

    // R9 line lookup
    for (int ln = 0; ln < 16; ln++) begin
      int e;
      e = 0;
      for (int k = 0; k < 11; k++) if (lines[k] == ln) e = 1 << k;
      map_line = 4'(ln);
      expect_val(5, 2'd0, e, "R9 map_mask");
    end

    // R1 latency and R6 masked bit stays in status
    irq_in[0] = 1'b1;
    tick(2);
    expect_val(0, 2'd0, 0, "R1 not yet set");
    expect_val(0, 2'd0, 1, "R1 set after three clocks");
    irq_in[0] = 1'b0;
    expect_val(1, 2'd0, 0, "R6 masked no irq");
    tick(20);
    expect_val(0, 2'd0, 1, "R5 still set");
    wr(2'd0, 8'h01);
    expect_val(0, 2'd0, 0, "R4 low ack");

    // R1 held level / falling edge do not set again
    irq_in[1] = 1'b1;
    tick(4);
    wr(2'd0, 8'h02);
    tick(5);
    expect_val(0, 2'd0, 0, "R1 held level no re-set");
    irq_in[1] = 1'b0;
    tick(4);
    expect_val(0, 2'd0, 0, "R1 falling edge no set");

    // R6 enable registers
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    expect_val(0, 2'd2, 8'hFF, "R6 enable low readback");
    expect_val(0, 2'd3, 8'h07, "R6 enable high readback");

    // R7 lowest pending first, R2 line order
    pulse(9);
    pulse(4);
    expect_val(3, 2'd0, 4, "R7 lowest index");
    expect_val(4, 2'd0, 7, "R2 line of bit 4");
    expect_val(0, 2'd1, 8'h02, "R3 high status");
    wr(2'd0, 8'h10);
    expect_val(3, 2'd0, 9, "R7 next index");
    expect_val(4, 2'd0, 14, "R2 line of bit 9");
    wr(2'd1, 8'h02);
    expect_val(1, 2'd0, 0, "R4 high ack irq low");
    expect_val(3, 2'd0, 0, "R7 idle index zero");
    expect_val(4, 2'd0, 0, "R7 idle line zero");

    // R2 R3 R4 every bit
    for (int k = 0; k < 11; k++) begin
      pulse(k);
      expect_val(0, 2'd0, (k < 8) ? (1 << k) : 0, "R3 low status per bit");
      expect_val(0, 2'd1, (k >= 8) ? (1 << (k - 8)) : 0, "R3 high status per bit");
      expect_val(3, 2'd0, k, "R7 index per bit");
      expect_val(4, 2'd0, lines[k], "R2 line per bit");
      expect_val(2, 2'd0, 1, "R7 valid per bit");
      if (k < 8) wr(2'd0, 8'(1 << k));
      else wr(2'd1, 8'(1 << (k - 8)));
      expect_val(1, 2'd0, 0, "R4 ack per bit");
    end

    // R4 ignored high bits and zero data
    pulse(10);
    wr(2'd1, 8'hFB);
    expect_val(0, 2'd1, 8'h04, "R4 high upper bits ignored");
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h00);
    expect_val(0, 2'd1, 8'h04, "R4 zero data no effect");
    wr(2'd1, 8'h04);
    expect_val(0, 2'd1, 8'h00, "R4 high ack bit 10");

    // R8 edge and ack on the same clock
    pulse(5);
    irq_in[5] = 1'b1;
    tick(2);
    wr(2'd0, 8'h20);
    expect_val(0, 2'd0, 8'h20, "R8 edge wins over ack");
    wr(2'd0, 8'h20);
    tick(3);
    expect_val(0, 2'd0, 8'h00, "R8 later ack clears");
    irq_in[5] = 1'b0;
    tick(3);

    // R6 disabling the enable drops irq but keeps status
    pulse(2);
    pulse(8);
    wr(2'd2, 8'h00);
    expect_val(3, 2'd0, 8, "R6 only high enabled");
    wr(2'd3, 8'h00);
    expect_val(1, 2'd0, 0, "R6 all masked irq low");
    expect_val(2, 2'd0, 0, "R6 all masked valid low");
    expect_val(0, 2'd0, 8'h04, "R6 masked status visible");
    expect_val(0, 2'd1, 8'h01, "R6 masked high status visible");

    tick(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule